// File: doc/BRIEF.md
# Balanced Ternary Digit Encoder with Dual Serial Output

This block takes signed binary audio samples and turns each one into a string of balanced-ternary digits. Each digit is -1, 0 or +1. The digits drive the switches of a differential ternary resistor ladder built in two halves.

A sample arrives on a valid/ready handshake. The block clamps the sample to the range the digits can represent and records a sticky clip flag whenever clamping occurs. It then converts the clamped value sequentially, producing one digit per clock. It works through the remainder of a running value modulo 3, starting from the least significant stage.

Each stage contributes one bit to each half. A +1 digit sets the bit for the positive half and a -1 digit sets the bit for the negative half. A 0 digit leaves both bits clear, so that stage stays at ground. The two bit vectors are framed and shifted out on two synchronous serial ports, one per half. Both ports share clock and frame timing. A new sample is taken only after the previous frame has left completely.

The controller has four states:
- `ST_IDLE` waits for a sample. The transition *accept* (valid while ready) goes to `ST_CONVERT`.
- `ST_CONVERT` runs one digit step per clock. The transition *last digit* goes to `ST_LAUNCH`.
- `ST_LAUNCH` loads both frame registers. The transition *frame loaded* (unconditional) goes to `ST_SHIFT`.
- `ST_SHIFT` waits for the serializer. The transition *frame done* returns to `ST_IDLE`.

Top module: `ternary_dac_encoder`

## Requirements
- R1: After reset, `busy` is 0, `in_ready` is 1, `clip_flag` is 0, and all serial clock, data and strobe outputs are 0.
- R2: A sample is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 1 only in the idle state. `busy` is 1 from the cycle after acceptance until the frame has been fully shifted out, and `in_ready` is 0 throughout that time.
- R3: With M = (3^20-1)/2 = 1743392200, an input above M is converted as M and an input below -M is converted as -M. The first such input sets `clip_flag`, which then stays 1 until reset. In-range inputs never set it.
- R4: Call stage i's positive-port bit p_i and its negative-port bit n_i, for i from 0 to 19. Then the sum over i of (p_i - n_i)·3^i equals the clamped sample.
- R5: For no stage are both the positive-port bit and the negative-port bit 1.
- R6: A sample of zero yields all-zero data on both ports, so every switch is at ground.
- R7: If |clamped sample| ≤ (3^k-1)/2, then every stage k and above is 0 on both ports, so only low-order stages toggle.
- R8: Each frame is 24 serial clock periods per port. Bits 1 to 20 carry stage 19 down to stage 0, the most significant stage first, and bits 21 to 24 are zero pad. Data changes only while the serial clock is low and is sampled on its rising edge.
- R9: The frame strobe of each port is 1 during the 24th bit of a frame only.
- R10: The two ports have identical serial clock and frame strobe waveforms, so every frame starts and ends on the same edge on both.
- R11: Outside a frame, serial clocks, data and strobes rest at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block can take a sample |
| in_sample | input | 32 | Signed two's-complement sample |
| busy | output | 1 | Conversion or frame in progress |
| clip_flag | output | 1 | Sticky: some input was clamped |
| pos_sclk | output | 1 | Serial clock, positive half |
| pos_sdata | output | 1 | Serial data, positive half |
| pos_fstrb | output | 1 | Frame strobe, positive half |
| neg_sclk | output | 1 | Serial clock, negative half |
| neg_sdata | output | 1 | Serial data, negative half |
| neg_fstrb | output | 1 | Frame strobe, negative half |

## Verification
The assertions assume two things about the inputs: reset is asserted from the first clock, and `in_valid` is only evaluated in combination with `in_ready`. With those inputs, the properties on clip stickiness, port symmetry, idle quietness and data-versus-clock phase hold for any sample value.

The stimulus always waits for `in_ready` before raising `in_valid`, and drops it one cycle later, so the handshake is never violated. The bench sweeps every sample from -300 to 300. It then applies the edges 0, ±1, ±M, ±(M+1) and the 32-bit extremes, followed by random 32-bit values. For each frame, it rebuilds the value from the sampled port bits and compares it with an arithmetic clamp.

// File: rtl/tdac_pkg.sv
package tdac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CONVERT = 2'd1,
        ST_LAUNCH  = 2'd2,
        ST_SHIFT   = 2'd3
    } tdac_state_e;

    localparam int LANE_POS = 0;
    localparam int LANE_NEG = 1;
    localparam int NUM_LANES = 2;

    function automatic longint pow3(input int n);
        longint acc;
        acc = 1;
        for (int i = 0; i < n; i++) begin
            acc = acc * 3;
        end
        return acc;
    endfunction

endpackage

// File: rtl/tdac_clamp.sv
module tdac_clamp #(
    parameter int SAMPLE_W = 32,
    parameter int NDIGITS  = 20,
    parameter int WORK_W   = SAMPLE_W + 2
) (
    input  logic [SAMPLE_W-1:0]      raw_i,
    output logic signed [WORK_W-1:0] value_o,
    output logic                     clipped_o
);
    import tdac_pkg::*;

    localparam longint MAXMAG = (pow3(NDIGITS) - 1) / 2;
    localparam logic signed [WORK_W-1:0] MAX_W = WORK_W'(MAXMAG);

    logic signed [63:0] wide;

    always_comb begin
        wide = {{(64-SAMPLE_W){raw_i[SAMPLE_W-1]}}, raw_i};
        if (wide > MAXMAG) begin
            value_o   = MAX_W;
            clipped_o = 1'b1;
        end else if (wide < -MAXMAG) begin
            value_o   = -MAX_W;
            clipped_o = 1'b1;
        end else begin
            value_o   = {{(WORK_W-SAMPLE_W){raw_i[SAMPLE_W-1]}}, raw_i};
            clipped_o = 1'b0;
        end
    end
endmodule

// File: rtl/tdac_digit_engine.sv
module tdac_digit_engine #(
    parameter int NDIGITS = 20,
    parameter int WORK_W  = 34
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic signed [WORK_W-1:0] value_i,
    input  logic                     step_i,
    output logic                     last_o,
    output logic [NDIGITS-1:0]       pos_vec_o,
    output logic [NDIGITS-1:0]       neg_vec_o
);
    localparam int CNT_W = $clog2(NDIGITS + 1);
    localparam logic signed [WORK_W-1:0] THREE = 3;
    localparam logic signed [WORK_W-1:0] ONE   = 1;

    logic signed [WORK_W-1:0] work_q;
    logic signed [WORK_W-1:0] rem;
    logic signed [WORK_W-1:0] adjusted;
    logic signed [WORK_W-1:0] quotient;
    logic [CNT_W-1:0]         idx_q;
    logic                     dig_pos;
    logic                     dig_neg;

    // balanced residue: 0 -> 0, 1 -> +1, 2 -> -1 (value bumped by one)
    always_comb begin
        rem = work_q % THREE;
        if (rem < 0) begin
            rem = rem + THREE;
        end
        dig_pos  = 1'b0;
        dig_neg  = 1'b0;
        adjusted = work_q;
        if (rem == ONE) begin
            dig_pos  = 1'b1;
            adjusted = work_q - ONE;
        end else if (rem == (THREE - ONE)) begin
            dig_neg  = 1'b1;
            adjusted = work_q + ONE;
        end
        quotient = adjusted / THREE;
    end

    assign last_o = step_i && (idx_q == CNT_W'(NDIGITS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q    <= '0;
            idx_q     <= '0;
            pos_vec_o <= '0;
            neg_vec_o <= '0;
        end else if (load_i) begin
            work_q    <= value_i;
            idx_q     <= '0;
            pos_vec_o <= '0;
            neg_vec_o <= '0;
        end else if (step_i) begin
            work_q           <= quotient;
            idx_q            <= idx_q + CNT_W'(1);
            pos_vec_o[idx_q] <= dig_pos;
            neg_vec_o[idx_q] <= dig_neg;
        end
    end
endmodule

// File: rtl/tdac_serializer.sv
module tdac_serializer #(
    parameter int FRAME_W    = 24,
    parameter int SCLK_HALF  = 2,
    parameter int LANES      = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_i,
    input  logic [LANES-1:0][FRAME_W-1:0] frame_i,
    output logic                          sclk_o,
    output logic                          fstrb_o,
    output logic [LANES-1:0]              sdata_o,
    output logic                          done_o
);
    localparam int DIV_W = $clog2(SCLK_HALF + 1);
    localparam int BIT_W = $clog2(FRAME_W + 1);

    logic             active_q;
    logic             sclk_q;
    logic [DIV_W-1:0] div_q;
    logic [BIT_W-1:0] bit_q;
    logic             tick;
    logic             last_bit;
    logic             shift_en;

    assign tick     = active_q && (div_q == DIV_W'(SCLK_HALF - 1));
    assign last_bit = (bit_q == BIT_W'(FRAME_W - 1));
    assign shift_en = tick && sclk_q && !last_bit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            sclk_q   <= 1'b0;
            div_q    <= '0;
            bit_q    <= '0;
            done_o   <= 1'b0;
        end else if (load_i) begin
            active_q <= 1'b1;
            sclk_q   <= 1'b0;
            div_q    <= '0;
            bit_q    <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (active_q) begin
                if (tick) begin
                    div_q <= '0;
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                    end else begin
                        sclk_q <= 1'b0;
                        if (last_bit) begin
                            active_q <= 1'b0;
                            done_o   <= 1'b1;
                        end else begin
                            bit_q <= bit_q + BIT_W'(1);
                        end
                    end
                end else begin
                    div_q <= div_q + DIV_W'(1);
                end
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            logic [FRAME_W-1:0] shreg_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    shreg_q <= '0;
                end else if (load_i) begin
                    shreg_q <= frame_i[g];
                end else if (shift_en) begin
                    shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
                end
            end
            assign sdata_o[g] = active_q && shreg_q[FRAME_W-1];
        end
    endgenerate

    assign sclk_o  = sclk_q;
    assign fstrb_o = active_q && last_bit;
endmodule

// File: rtl/ternary_dac_encoder.sv
module ternary_dac_encoder #(
    parameter int SAMPLE_W  = 32,
    parameter int NDIGITS   = 20,
    parameter int FRAME_W   = 24,
    parameter int SCLK_HALF = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_sample,
    output logic                busy,
    output logic                clip_flag,
    output logic                pos_sclk,
    output logic                pos_sdata,
    output logic                pos_fstrb,
    output logic                neg_sclk,
    output logic                neg_sdata,
    output logic                neg_fstrb
);
    import tdac_pkg::*;

    localparam int WORK_W = SAMPLE_W + 2;
    localparam int PAD_W  = FRAME_W - NDIGITS;

    tdac_state_e state_q, state_d;

    logic signed [WORK_W-1:0]             clamped;
    logic                                 clipped;
    logic                                 accept;
    logic                                 eng_last;
    logic [NDIGITS-1:0]                   pos_vec;
    logic [NDIGITS-1:0]                   neg_vec;
    logic [NUM_LANES-1:0][FRAME_W-1:0]    frames;
    logic [NUM_LANES-1:0]                 sdata;
    logic                                 ser_sclk;
    logic                                 ser_fstrb;
    logic                                 ser_done;
    logic                                 do_step;
    logic                                 do_launch;

    tdac_clamp #(.SAMPLE_W(SAMPLE_W), .NDIGITS(NDIGITS), .WORK_W(WORK_W)) u_clamp (
        .raw_i     (in_sample),
        .value_o   (clamped),
        .clipped_o (clipped)
    );

    tdac_digit_engine #(.NDIGITS(NDIGITS), .WORK_W(WORK_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .value_i   (clamped),
        .step_i    (do_step),
        .last_o    (eng_last),
        .pos_vec_o (pos_vec),
        .neg_vec_o (neg_vec)
    );

    assign frames[LANE_POS] = {pos_vec, {PAD_W{1'b0}}};
    assign frames[LANE_NEG] = {neg_vec, {PAD_W{1'b0}}};

    tdac_serializer #(.FRAME_W(FRAME_W), .SCLK_HALF(SCLK_HALF), .LANES(NUM_LANES)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (do_launch),
        .frame_i (frames),
        .sclk_o  (ser_sclk),
        .fstrb_o (ser_fstrb),
        .sdata_o (sdata),
        .done_o  (ser_done)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (in_valid) state_d = ST_CONVERT;
            ST_CONVERT: if (eng_last) state_d = ST_LAUNCH;
            ST_LAUNCH:  state_d = ST_SHIFT;
            ST_SHIFT:   if (ser_done) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = (state_q == ST_IDLE);
        busy      = (state_q != ST_IDLE);
        accept    = in_ready && in_valid;
        do_step   = (state_q == ST_CONVERT);
        do_launch = (state_q == ST_LAUNCH);
        pos_sclk  = ser_sclk;
        neg_sclk  = ser_sclk;
        pos_fstrb = ser_fstrb;
        neg_fstrb = ser_fstrb;
        pos_sdata = sdata[LANE_POS];
        neg_sdata = sdata[LANE_NEG];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clip_flag <= 1'b0;
        end else if (accept && clipped) begin
            clip_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/tdac_checker.sv
module tdac_checker (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic busy,
    input logic clip_flag,
    input logic pos_sclk,
    input logic pos_sdata,
    input logic pos_fstrb,
    input logic neg_sclk,
    input logic neg_sdata,
    input logic neg_fstrb
);
    assert_ready_only_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !busy);

    assert_accept_goes_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> busy);

    assert_clip_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clip_flag |=> clip_flag);

    assert_no_double_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(pos_sdata && neg_sdata));

    assert_data_moves_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(pos_sdata) || !$stable(neg_sdata)) |-> !pos_sclk);

    assert_ports_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_sclk == neg_sclk) && (pos_fstrb == neg_fstrb));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!pos_sclk && !pos_sdata && !neg_sdata && !pos_fstrb));
endmodule

bind ternary_dac_encoder tdac_checker u_chk (.*);

// File: tb/ternary_dac_encoder_test.sv
`timescale 1ns/1ps
module ternary_dac_encoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_sample = '0;
    logic        in_ready, busy, clip_flag;
    logic        pos_sclk, pos_sdata, pos_fstrb;
    logic        neg_sclk, neg_sdata, neg_fstrb;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ternary_dac_encoder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sample(in_sample), .busy(busy), .clip_flag(clip_flag),
        .pos_sclk(pos_sclk), .pos_sdata(pos_sdata), .pos_fstrb(pos_fstrb),
        .neg_sclk(neg_sclk), .neg_sdata(neg_sdata), .neg_fstrb(neg_fstrb)
    );

    longint maxmag;

    function automatic longint p3(input int n);
        longint a = 1;
        for (int i = 0; i < n; i++) a = a * 3;
        return a;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_sample(input logic [31:0] raw);
        longint x, expv, recon, mag;
        int k, top_nz;
        bit both, strobe_bad, pad_bad, align_bad;
        logic [23:0] pb, nb;
        x = longint'(signed'(raw));
        expv = (x > maxmag) ? maxmag : ((x < -maxmag) ? -maxmag : x);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_sample = raw;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(busy && !in_ready, "R2 busy after accept", longint'({busy, in_ready}), 2);
        strobe_bad = 0; align_bad = 0;
        for (int b = 0; b < 24; b++) begin
            @(posedge pos_sclk);
            #1;
            pb[23-b] = pos_sdata;
            nb[23-b] = neg_sdata;
            if (pos_fstrb != (b == 23)) strobe_bad = 1;
            if (neg_sclk != pos_sclk || neg_fstrb != pos_fstrb) align_bad = 1;
        end
        @(negedge clk);
        while (busy) @(negedge clk);
        // rebuild: pb[23] is stage 19, pb[4] is stage 0
        recon = 0; both = 0; top_nz = -1;
        for (int s = 0; s < 20; s++) begin
            recon += (longint'(pb[4+s]) - longint'(nb[4+s])) * p3(s);
            if (pb[4+s] && nb[4+s]) both = 1;
            if (pb[4+s] || nb[4+s]) top_nz = s;
        end
        pad_bad = (pb[3:0] != 0) || (nb[3:0] != 0);
        check(recon == expv, "R4 value rebuild", recon, expv);
        check(!both, "R5 both halves set", 1, 0);
        check(!pad_bad, "R8 pad bits", longint'({pb[3:0], nb[3:0]}), 0);
        check(!strobe_bad, "R9 strobe on last bit", 1, 0);
        check(!align_bad, "R10 port alignment", 1, 0);
        mag = (expv < 0) ? -expv : expv;
        k = 0;
        while ((p3(k) - 1) / 2 < mag) k++;
        check(top_nz < k, "R7 high stages grounded", top_nz, k - 1);
        if (expv == 0) check(pb == 0 && nb == 0, "R6 zero grounds all", longint'(pb | nb), 0);
        check(!pos_sclk && !neg_sclk && !pos_sdata && !neg_sdata && !pos_fstrb && in_ready,
              "R11 idle outputs", longint'({pos_sclk, pos_sdata, neg_sdata, in_ready}), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        maxmag = (p3(20) - 1) / 2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && in_ready && !clip_flag && !pos_sclk && !neg_sclk && !pos_sdata
              && !neg_sdata && !pos_fstrb && !neg_fstrb, "R1 reset state",
              longint'({busy, in_ready, clip_flag}), 2);

        for (int v = -300; v <= 300; v++) run_sample(32'(v));
        check(clip_flag == 0, "R3 no clip in range", clip_flag, 0);

        run_sample(32'd0);
        run_sample(32'd1);
        run_sample(-32'sd1);
        run_sample(32'(maxmag));
        run_sample(32'(-maxmag));
        check(clip_flag == 0, "R3 no clip at limit", clip_flag, 0);
        run_sample(32'(maxmag + 1));
        check(clip_flag == 1, "R3 clip set", clip_flag, 1);
        run_sample(32'd5);
        check(clip_flag == 1, "R3 clip sticky", clip_flag, 1);
        run_sample(32'(-maxmag - 1));
        run_sample(32'h8000_0000);
        run_sample(32'h7fff_ffff);

        for (int r = 0; r < 150; r++) run_sample($urandom);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule